// File: doc/BRIEF.md
# Interrupt Timestamp Capture Ring

This block records when an interrupt event happens. Each time the selected event fires while its channel is enabled, the current value of a free-running nanosecond counter is stored in a small circular buffer. A single consumer pulls the stored times out in arrival order through a one-request, one-response read port. The writer keeps a slot index and a running total of captures. The reader keeps its own slot index and a running total of what it has consumed.

The read side does not use full or empty flags. It finds out that it has been lapped by subtracting its consumed total from the capture total. When that gap is larger than the ring, the read is refused with an overrun response. The reader then jumps to the writer's current position and total, so the next read starts from fresh data. A data-available output tells the consumer that the two totals differ.

Top module: `ts_capture_ring`

## Requirements
- R1: After reset, data_avail is 0, no response strobe is active, and the first read request gets a would-block response.
- R2: On a capture (evt high while chan_en is high), ns_time is stored in the slot given by the write index. The write index then advances, wrapping from DEPTH-1 (15) to 0, and the 32-bit capture total rises by one.
- R3: In a cycle where chan_en goes from low to high, the write index returns to 0, and a capture in that same cycle goes to slot 0. While chan_en is low, evt is not captured.
- R4: If a read finds that the capture total minus the consumed total, taken as an unsigned 32-bit value, is greater than DEPTH, the response is overrun. The reader's total and index are then loaded with the writer's total and index.
- R5: The fill level is (write index - read index) modulo DEPTH. A read at level 0 that is not an overrun gets a would-block response and leaves the reader state unchanged. This holds even when the gap is exactly DEPTH.
- R6: A successful read returns the entry at the read index. The read index then advances, wrapping at DEPTH, and the consumed total rises by one.
- R7: data_avail is high exactly when the capture total differs from the consumed total.
- R8: A capture and a read in the same cycle both take effect. The read's level and overrun checks use the state from before that cycle's updates.
- R9: The response comes one cycle after rd_req. It is exactly one of rd_valid (with rd_data), rd_wouldblock or rd_overrun. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 1 | Interrupt event for the channel |
| chan_en | input | 1 | Channel enable; a rising level re-arms the write index |
| ns_time | input | 64 | Free-running nanosecond time |
| rd_req | input | 1 | Read request strobe |
| rd_valid | output | 1 | Read succeeded; rd_data holds the entry |
| rd_data | output | 64 | Timestamp returned by a successful read |
| rd_wouldblock | output | 1 | Read refused because the ring is empty |
| rd_overrun | output | 1 | Read refused because the reader was lapped; the reader has been resynchronised |
| data_avail | output | 1 | Capture total differs from consumed total |

## Verification
The bound checker tests on every cycle that each response is single and was requested. It also checks that an overrun loads the writer's pre-update total and index into the reader, that a successful read steps the reader by one, and that a would-block or a disabled channel leaves the totals unchanged. The stored timestamp values, wrap-around, the trap where a gap of exactly DEPTH reads as empty, and re-arming the index on enable can only be shown by the bench scenarios. The bench compares these against its own ring model, including cycles where a capture and a read happen together.

// File: rtl/ts_ring_pkg.sv
package ts_ring_pkg;
   typedef enum logic [1:0] {
      RSP_NONE    = 2'd0,
      RSP_DATA    = 2'd1,
      RSP_EMPTY   = 2'd2,
      RSP_OVERRUN = 2'd3
   } rsp_e;
endpackage

// File: rtl/ts_ring_wr.sv
module ts_ring_wr #(
   parameter int DEPTH        = 16,
   parameter int CNT_W        = 32,
   parameter bit EDGE_CAPTURE = 1'b0,
   localparam int IDX_W       = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             chan_en,
   output logic             we,
   output logic [IDX_W-1:0] waddr,
   output logic [IDX_W-1:0] wr_idx,
   output logic [CNT_W-1:0] cap_cnt
);
   logic en_q;
   logic arm;
   logic fire;
   logic [IDX_W-1:0] base;

   // variant: capture every high cycle, or only the rising edge of evt
   generate
      if (EDGE_CAPTURE) begin : g_edge
         logic evt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) evt_q <= 1'b0;
            else        evt_q <= evt;
         end
         assign fire = evt & ~evt_q & chan_en;
      end else begin : g_level
         assign fire = evt & chan_en;
      end
   endgenerate

   assign arm   = chan_en & ~en_q;
   assign base  = arm ? '0 : wr_idx;
   assign we    = fire;
   assign waddr = base;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         wr_idx  <= '0;
         cap_cnt <= '0;
      end else begin
         en_q   <= chan_en;
         wr_idx <= base + IDX_W'(fire);
         if (fire) cap_cnt <= cap_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ts_ring_store.sv
module ts_ring_store #(
   parameter int DEPTH  = 16,
   parameter int TS_W   = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [TS_W-1:0]  wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [TS_W-1:0]  rdata
);
   logic [TS_W-1:0] slot [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (we && waddr == IDX_W'(i)) slot[i] <= wdata;
         end
      end
   endgenerate

   assign rdata = slot[raddr];
endmodule

// File: rtl/ts_ring_rd.sv
module ts_ring_rd
   import ts_ring_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int TS_W   = 64,
   parameter int CNT_W  = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [CNT_W-1:0] cap_cnt,
   input  logic [TS_W-1:0]  rdata,
   output logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_cnt,
   output logic             rd_valid,
   output logic [TS_W-1:0]  rd_data,
   output logic             rd_wouldblock,
   output logic             rd_overrun
);
   localparam logic [CNT_W-1:0] GAP_MAX = CNT_W'(DEPTH);

   logic [CNT_W-1:0] gap;
   logic [IDX_W-1:0] level;
   rsp_e             rsp;

   assign gap   = cap_cnt - rd_cnt;   // unsigned, survives total wrap
   assign level = wr_idx - rd_idx;    // modulo DEPTH by width

   always_comb begin
      rsp = RSP_NONE;
      if (rd_req) begin
         if (gap > GAP_MAX)    rsp = RSP_OVERRUN;
         else if (level == '0) rsp = RSP_EMPTY;
         else                  rsp = RSP_DATA;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_idx        <= '0;
         rd_cnt        <= '0;
         rd_valid      <= 1'b0;
         rd_wouldblock <= 1'b0;
         rd_overrun    <= 1'b0;
         rd_data       <= '0;
      end else begin
         rd_valid      <= (rsp == RSP_DATA);
         rd_wouldblock <= (rsp == RSP_EMPTY);
         rd_overrun    <= (rsp == RSP_OVERRUN);
         unique case (rsp)
            RSP_OVERRUN: begin
               rd_cnt <= cap_cnt;
               rd_idx <= wr_idx;
            end
            RSP_DATA: begin
               rd_data <= rdata;
               rd_idx  <= rd_idx + 1'b1;
               rd_cnt  <= rd_cnt + 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ts_capture_ring.sv
module ts_capture_ring #(
   parameter int DEPTH        = 16,
   parameter int TS_W         = 64,
   parameter int CNT_W        = 32,
   parameter bit EDGE_CAPTURE = 1'b0,
   localparam int IDX_W       = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt,
   input  logic            chan_en,
   input  logic [TS_W-1:0] ns_time,
   input  logic            rd_req,
   output logic            rd_valid,
   output logic [TS_W-1:0] rd_data,
   output logic            rd_wouldblock,
   output logic            rd_overrun,
   output logic            data_avail
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (CNT_W <= IDX_W + 1) begin : g_bad_cnt
         $error("CNT_W must exceed the index width by more than one bit");
      end
   endgenerate

   logic             we;
   logic [IDX_W-1:0] waddr;
   logic [IDX_W-1:0] wr_idx;
   logic [CNT_W-1:0] cap_cnt;
   logic [IDX_W-1:0] rd_idx;
   logic [CNT_W-1:0] rd_cnt;
   logic [TS_W-1:0]  rdata;

   ts_ring_wr #(.DEPTH(DEPTH), .CNT_W(CNT_W), .EDGE_CAPTURE(EDGE_CAPTURE)) u_wr (
      .clk(clk), .rst_n(rst_n), .evt(evt), .chan_en(chan_en),
      .we(we), .waddr(waddr), .wr_idx(wr_idx), .cap_cnt(cap_cnt)
   );

   ts_ring_store #(.DEPTH(DEPTH), .TS_W(TS_W)) u_store (
      .clk(clk), .we(we), .waddr(waddr), .wdata(ns_time),
      .raddr(rd_idx), .rdata(rdata)
   );

   ts_ring_rd #(.DEPTH(DEPTH), .TS_W(TS_W), .CNT_W(CNT_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
      .wr_idx(wr_idx), .cap_cnt(cap_cnt), .rdata(rdata),
      .rd_idx(rd_idx), .rd_cnt(rd_cnt),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_wouldblock(rd_wouldblock), .rd_overrun(rd_overrun)
   );

   assign data_avail = (cap_cnt != rd_cnt);
endmodule

// File: rtl/ts_ring_checker.sv
module ts_ring_checker #(
   parameter int CNT_W        = 32,
   parameter int IDX_W        = 4,
   parameter bit EDGE_CAPTURE = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             evt,
   input logic             chan_en,
   input logic             rd_req,
   input logic             rd_valid,
   input logic             rd_wouldblock,
   input logic             rd_overrun,
   input logic [CNT_W-1:0] cap_cnt,
   input logic [CNT_W-1:0] rd_cnt,
   input logic [IDX_W-1:0] wr_idx,
   input logic [IDX_W-1:0] rd_idx
);
   a_r9_single_response: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, rd_wouldblock, rd_overrun}));

   a_r9_response_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> (rd_valid || rd_wouldblock || rd_overrun));

   a_r9_no_spurious_response: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !(rd_valid || rd_wouldblock || rd_overrun));

   a_r4_resync_count: assert property (@(posedge clk) disable iff (!rst_n)
      rd_overrun |-> (rd_cnt == $past(cap_cnt) && rd_idx == $past(wr_idx)));

   a_r6_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_cnt == $past(rd_cnt) + 1'b1 && rd_idx == $past(rd_idx) + 1'b1));

   a_r5_block_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wouldblock |-> (rd_cnt == $past(rd_cnt) && rd_idx == $past(rd_idx)));

   a_r3_disabled_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> cap_cnt == $past(cap_cnt));

   generate
      if (!EDGE_CAPTURE) begin : g_lvl_chk
         a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (evt && chan_en) |=> cap_cnt == $past(cap_cnt) + 1'b1);
      end
   endgenerate
endmodule

bind ts_capture_ring ts_ring_checker #(
   .CNT_W(CNT_W), .IDX_W(IDX_W), .EDGE_CAPTURE(EDGE_CAPTURE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt(evt), .chan_en(chan_en), .rd_req(rd_req),
   .rd_valid(rd_valid), .rd_wouldblock(rd_wouldblock), .rd_overrun(rd_overrun),
   .cap_cnt(cap_cnt), .rd_cnt(rd_cnt), .wr_idx(wr_idx), .rd_idx(rd_idx)
);

// File: tb/test_ts_capture_ring.sv
module test_ts_capture_ring;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt = 1'b0;
   logic        chan_en = 1'b0;
   logic [63:0] ns_time = '0;
   logic        rd_req = 1'b0;
   logic        rd_valid;
   logic [63:0] rd_data;
   logic        rd_wouldblock;
   logic        rd_overrun;
   logic        data_avail;

   always #4 clk = ~clk;   // 125 MHz

   ts_capture_ring i_ts_capture_ring (
      .clk(clk), .rst_n(rst_n), .evt(evt), .chan_en(chan_en), .ns_time(ns_time),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_wouldblock(rd_wouldblock), .rd_overrun(rd_overrun), .data_avail(data_avail)
   );

   // reference model of the ring
   logic [63:0] m_mem [DEPTH];
   logic [3:0]  m_widx = '0, m_ridx = '0;
   logic [31:0] m_cnt = '0, m_rcnt = '0;
   logic        m_enq = 1'b0;
   logic [63:0] t_now = 64'd1000;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // response code: 0 none, 1 data, 2 would-block, 3 overrun
   function automatic int exp_kind(input logic rq);
      logic [31:0] gap;
      logic [3:0]  lvl;
      gap = m_cnt - m_rcnt;
      lvl = m_widx - m_ridx;
      if (!rq) return 0;
      if (gap > 32'(DEPTH)) return 3;
      if (lvl == 4'd0) return 2;
      return 1;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic e, input logic en, input logic rq, input string tag);
      int          k;
      logic [63:0] d;
      logic        arm, fire;
      logic [3:0]  base;
      @(negedge clk);
      evt = e; chan_en = en; rd_req = rq;
      t_now += 64'(1 + $urandom % 40);
      ns_time = t_now;
      k = exp_kind(rq);
      d = m_mem[m_ridx];
      if (k == 3) begin m_rcnt = m_cnt; m_ridx = m_widx; end
      if (k == 1) begin m_ridx = m_ridx + 1'b1; m_rcnt = m_rcnt + 1; end
      arm  = en & ~m_enq;
      fire = e & en;
      base = arm ? 4'd0 : m_widx;
      if (fire) begin m_mem[base] = t_now; m_cnt = m_cnt + 1; end
      m_widx = base + 4'(fire);
      m_enq  = en;
      @(posedge clk); #2;
      check(tag, "response", 64'({rd_overrun, rd_wouldblock, rd_valid}),
            64'(k == 3 ? 4 : k == 2 ? 2 : k == 1 ? 1 : 0));
      if (k == 1) check(tag, "data", rd_data, d);
      check("R7", "data_avail", 64'(data_avail), 64'(m_cnt != m_rcnt));
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      check("R1", "rst valid", 64'(rd_valid), 64'd0);
      check("R1", "rst block", 64'(rd_wouldblock), 64'd0);
      check("R1", "rst avail", 64'(data_avail), 64'd0);
      @(negedge clk); rst_n = 1'b1;
      step(0, 1, 1, "R1");
      // R2/R6: capture three, read them back, then empty R5
      for (int i = 0; i < 3; i++) step(1, 1, 0, "R2");
      for (int i = 0; i < 3; i++) step(0, 1, 1, "R6");
      step(0, 1, 1, "R5");
      // R4: overrun after 20 captures, then resynchronised ring is empty
      for (int i = 0; i < 20; i++) step(1, 1, 0, "R2");
      step(0, 1, 1, "R4");
      step(0, 1, 1, "R4");
      // R5: gap of exactly DEPTH looks empty
      for (int i = 0; i < DEPTH; i++) step(1, 1, 0, "R2");
      step(0, 1, 1, "R5");
      step(1, 1, 0, "R2");
      step(0, 1, 1, "R4");
      // R3: disabled events ignored, re-enable re-arms index
      step(1, 0, 0, "R3");
      step(1, 0, 1, "R3");
      step(1, 1, 0, "R3");
      step(1, 1, 1, "R3");
      step(0, 1, 1, "R3");
      // R8: simultaneous capture and read
      for (int i = 0; i < 6; i++) step(1, 1, 1, "R8");
      step(0, 1, 1, "R8");
      // randomized traffic, mixed rates
      for (int i = 0; i < 4000; i++) begin
         int bias;
         bias = (i / 500) % 2 ? 70 : 30;
         step(($urandom % 100) < bias, ($urandom % 100) >= 2,
              ($urandom % 100) < 45, "R8");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule